// File: doc/BRIEF.md
# Multi-Channel Phase Tag Queue

This block gathers 24-bit phase tags produced by up to 32 reference-input channels and up to 8 output channels and funnels them into a single 32-entry queue. A bus host drains that queue one word at a time. Each channel has three inputs: an enable, a one-cycle valid strobe and a tag value. Any channel whose strobe cannot go into the queue at once waits in a one-deep holding slot of its own. A round-robin arbiter moves one held tag per cycle into the queue. It stamps the tag with a channel identifier and a discontinuity bit.

A tag can be lost in two ways: the queue is full when the tag wins arbitration, or a newer strobe arrives while the older tag still occupies its slot. Either loss sets a sticky marker. The next entry written into the queue carries the discontinuity bit, and the marker then clears. The host sees an empty flag and a level interrupt that is high while at least one entry waits. It pulls the oldest entry with a one-cycle read request.

Top module: `tag_collect_queue`

## Requirements
- R1: A readout word has the discontinuity bit at bit 31, the channel identifier at bits 30:24, and the tag value at bits 23:0.
- R2: Reference channel i is stamped with identifier i. Output channel j is stamped with identifier 32+j.
- R3: The queue holds at most 32 entries. A tag that wins arbitration while 32 entries are held is discarded.
- R4: After any lost tag, the next entry written carries discontinuity 1. Entries written after that one carry 0 until another tag is lost.
- R5: A strobe on a channel whose enable is 0 is ignored. It stores nothing and does not set the loss marker.
- R6: Held tags move into the queue one per cycle in round-robin order. The search starts at the index after the last granted channel, and after reset it starts at reference channel 0. Reference channels take indices 0 to 31 and output channels take indices 32 to 39.
- R7: Each channel holds one tag. A new strobe that arrives while the channel's slot is occupied and not granted in that cycle is lost and sets the loss marker.
- R8: A read request returns the oldest entry on rd_data one cycle later and removes it from the queue. A read of an empty queue returns 0 and changes nothing. Without a read request, rd_data holds its value.
- R9: Consider a strobe sampled at clock edge k. Its entry is counted in the queue after edge k+1, at which point q_empty falls and irq rises. irq is high exactly while q_empty is low.
- R10: While reset is held, rd_data is 0, q_empty is 1 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | N_REF | Per reference channel tag enable |
| ref_stb | input | N_REF | Per reference channel tag-valid strobe |
| ref_tag | input | N_REF*24 | Reference tags, channel i at bits 24i+23:24i |
| out_en | input | N_OUT | Per output channel tag enable |
| out_stb | input | N_OUT | Per output channel tag-valid strobe |
| out_tag | input | N_OUT*24 | Output tags, channel j at bits 24j+23:24j |
| rd_req | input | 1 | Host pop request, one entry per cycle it is high |
| rd_data | output | 32 | Entry returned by the last read |
| q_empty | output | 1 | Queue holds no entry |
| irq | output | 1 | Level interrupt, high while entries wait |

## Verification
Each strobe takes two clock edges to reach the queue: one edge into the channel slot and one through the arbiter into the queue. A read result appears one edge after the request. Inputs change on the falling clock edge. The reference model is advanced on each rising edge from those stable inputs, and it is compared against rd_data, q_empty and irq on the following falling edge. The directed checks wait out the two-edge entry latency before popping, and they read rd_data on the falling edge right after the request edge.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  localparam int TAG_W       = 24;
  localparam int ID_W        = 7;
  localparam int REF_ID_SPAN = 32;
  localparam int ENTRY_W     = 1 + ID_W + TAG_W;

  typedef struct packed {
    logic             disc;
    logic [ID_W-1:0]  chan;
    logic [TAG_W-1:0] tag;
  } tag_entry_t;
endpackage

// File: rtl/tagq_slot.sv
module tagq_slot
  import tagq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             grant,
  output logic             vld,
  output logic [TAG_W-1:0] tag_q,
  output logic             lost
);
  logic take;

  // A strobe is accepted when the slot is free or is emptied by a grant this cycle.
  assign take = en && stb && (!vld || grant);
  assign lost = en && stb && vld && !grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (take) begin
      vld <= 1'b1;
    end else if (grant) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) tag_q <= tag_in;
  end
endmodule

// File: rtl/tagq_rr_arb.sv
module tagq_rr_arb #(
  parameter int N  = 40,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last;
  int            k;

  always_comb begin
    gnt     = '0;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    k       = 0;
    for (int i = 0; i < N; i++) begin
      k = int'(last) + 1 + i;
      if (k >= N) k = k - N;
      if (!gnt_vld && req[k]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(k);
        gnt[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= IW'(N - 1);
    end else if (gnt_vld) begin
      last <= gnt_idx;
    end
  end
endmodule

// File: rtl/tagq_fifo.sv
module tagq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign level = cnt;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_req && (cnt != '0);
  assign cnt_n = cnt + CW'(do_wr) - CW'(do_rd);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_req) begin
      rd_data <= do_rd ? mem[rp] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt   <= cnt_n;
      empty <= (cnt_n == '0);
    end
  end
endmodule

// File: rtl/tag_collect_queue.sv
module tag_collect_queue
  import tagq_pkg::*;
#(
  parameter int N_REF = 32,
  parameter int N_OUT = 8,
  parameter int DEPTH = 32,
  localparam int N_CH = N_REF + N_OUT,
  localparam int IW   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_REF-1:0]       ref_en,
  input  logic [N_REF-1:0]       ref_stb,
  input  logic [N_REF*TAG_W-1:0] ref_tag,
  input  logic [N_OUT-1:0]       out_en,
  input  logic [N_OUT-1:0]       out_stb,
  input  logic [N_OUT*TAG_W-1:0] out_tag,
  input  logic                   rd_req,
  output logic [ENTRY_W-1:0]     rd_data,
  output logic                   q_empty,
  output logic                   irq
);
  logic [N_CH-1:0]       ch_en, ch_stb, slot_vld, slot_lost, arb_gnt;
  logic [N_CH*TAG_W-1:0] ch_tag;
  logic [TAG_W-1:0]      slot_tag [N_CH];
  logic                  gnt_vld;
  logic [IW-1:0]         gnt_idx;
  logic                  q_full, drop_mark, drop_now, wr_ok;
  logic [CW-1:0]         q_level;
  tag_entry_t            wr_entry;

  // Reference channels take the low indices, output channels follow.
  assign ch_en  = {out_en, ref_en};
  assign ch_stb = {out_stb, ref_stb};
  assign ch_tag = {out_tag, ref_tag};

  for (genvar c = 0; c < N_CH; c++) begin : g_slot
    tagq_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .en     (ch_en[c]),
      .stb    (ch_stb[c]),
      .tag_in (ch_tag[c*TAG_W +: TAG_W]),
      .grant  (arb_gnt[c]),
      .vld    (slot_vld[c]),
      .tag_q  (slot_tag[c]),
      .lost   (slot_lost[c])
    );
  end

  tagq_rr_arb #(.N(N_CH)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (slot_vld),
    .gnt     (arb_gnt),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  always_comb begin
    wr_entry.disc = drop_mark;
    wr_entry.tag  = slot_tag[gnt_idx];
    if (int'(gnt_idx) < N_REF) wr_entry.chan = ID_W'(gnt_idx);
    else                       wr_entry.chan = ID_W'(int'(gnt_idx) - N_REF + REF_ID_SPAN);
  end

  assign wr_ok    = gnt_vld && !q_full;
  assign drop_now = (gnt_vld && q_full) || (|slot_lost);

  always_ff @(posedge clk) begin
    if (rst) drop_mark <= 1'b0;
    else     drop_mark <= (wr_ok ? 1'b0 : drop_mark) | drop_now;
  end

  tagq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (gnt_vld),
    .wr_data (wr_entry),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .empty   (q_empty),
    .full    (q_full),
    .level   (q_level)
  );

  assign irq = !q_empty;
endmodule

// File: rtl/tag_collect_queue_chk.sv
module tag_collect_queue_chk #(
  parameter int DEPTH = 32,
  parameter int N_CH  = 40,
  parameter int W     = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req,
  input logic [W-1:0]  rd_data,
  input logic          q_empty,
  input logic          q_full,
  input logic [CW-1:0] q_level,
  input logic [N_CH-1:0] gnt
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    q_level <= CW'(DEPTH));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (q_full && !rd_req) |=> $stable(q_level));

  p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && q_empty) |=> (rd_data == '0));

  p_hold_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));

  p_empty_tracks_level_r9: assert property (@(posedge clk) disable iff (rst)
    q_empty == (q_level == '0));
endmodule

bind tag_collect_queue tag_collect_queue_chk #(
  .DEPTH (DEPTH),
  .N_CH  (N_CH),
  .W     (tagq_pkg::ENTRY_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_req  (rd_req),
  .rd_data (rd_data),
  .q_empty (q_empty),
  .q_full  (q_full),
  .q_level (q_level),
  .gnt     (arb_gnt)
);

// File: tb/tag_collect_queue_bench.sv
module tag_collect_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int NO = 8;
  localparam int NCH = NR + NO;
  localparam int DEPTH = 32;
  localparam int TW = 24;

  logic clk, rst, rd_req;
  logic [NR-1:0] ref_en, ref_stb;
  logic [NR*TW-1:0] ref_tag;
  logic [NO-1:0] out_en, out_stb;
  logic [NO*TW-1:0] out_tag;
  logic [31:0] rd_data;
  logic q_empty, irq;

  tag_collect_queue u_tag_collect_queue (
    .clk(clk), .rst(rst),
    .ref_en(ref_en), .ref_stb(ref_stb), .ref_tag(ref_tag),
    .out_en(out_en), .out_stb(out_stb), .out_tag(out_tag),
    .rd_req(rd_req), .rd_data(rd_data), .q_empty(q_empty), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  wire [NCH-1:0]    all_en  = {out_en, ref_en};
  wire [NCH-1:0]    all_stb = {out_stb, ref_stb};
  wire [NCH*TW-1:0] all_tag = {out_tag, ref_tag};

  logic [31:0] mq [$];
  bit          pv [NCH];
  bit          pv0 [NCH];
  logic [TW-1:0] pt [NCH];
  int          mlast, cnt0, g, kk;
  bit          mmark;
  logic [31:0] m_rd;
  bit          started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      mq.delete();
      for (int c = 0; c < NCH; c++) pv[c] = 0;
      mlast = NCH - 1;
      mmark = 0;
      m_rd = '0;
    end else begin
      cnt0 = mq.size();
      pv0 = pv;
      g = -1;
      if (rd_req) begin
        if (cnt0 > 0) m_rd = mq.pop_front();
        else m_rd = '0;
      end
      for (int i = 0; i < NCH; i++) begin
        kk = (mlast + 1 + i) % NCH;
        if (g < 0 && pv0[kk]) g = kk;
      end
      if (g >= 0) begin
        if (cnt0 < DEPTH) begin
          mq.push_back({mmark, (g < NR) ? 7'(g) : 7'(32 + g - NR), pt[g]});
          mmark = 0;
        end else begin
          mmark = 1;
        end
        mlast = g;
        pv[g] = 0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (all_en[c] && all_stb[c]) begin
          if (pv0[c] && c != g) mmark = 1;
          else begin
            pv[c] = 1;
            pt[c] = all_tag[c*TW +: TW];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(rd_data, m_rd, "R8 per-cycle readout");
      check({31'b0, q_empty}, {31'b0, mq.size() == 0}, "R9 per-cycle empty");
      check({31'b0, irq}, {31'b0, mq.size() != 0}, "R9 per-cycle irq");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_stb(input int c, input logic [TW-1:0] t);
    if (c < NR) begin
      ref_stb[c] = 1'b1;
      ref_tag[c*TW +: TW] = t;
    end else begin
      out_stb[c-NR] = 1'b1;
      out_tag[(c-NR)*TW +: TW] = t;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ref_stb = '0;
    out_stb = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pop(output logic [31:0] d);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data;
  endtask

  logic [31:0] d;

  initial begin
    rst = 1'b1; rd_req = 1'b0;
    ref_en = '1; out_en = '1; ref_stb = '0; out_stb = '0;
    ref_tag = '0; out_tag = '0;
    idle(3);
    check(rd_data, 32'h0, "R10 reset rd_data");
    check({31'b0, q_empty}, 32'h1, "R10 reset q_empty");
    check({31'b0, irq}, 32'h0, "R10 reset irq");
    rst = 1'b0;
    idle(1);

    // R6 / R2 / R1: simultaneous strobes after reset start at index 0
    set_stb(0, 24'h000011); set_stb(3, 24'h000033);
    set_stb(10, 24'h0000AA); set_stb(33, 24'h000077);
    tick(); idle(6);
    pop(d); check(d, {1'b0, 7'd0, 24'h000011}, "R6 first grant ch0 (R1 format)");
    pop(d); check(d, {1'b0, 7'd3, 24'h000033}, "R6 second grant ch3");
    pop(d); check(d, {1'b0, 7'd10, 24'h0000AA}, "R6 third grant ch10");
    pop(d); check(d, {1'b0, 7'd33, 24'h000077}, "R2 output ch1 id 33");

    // R6 rotation: after granting ch2, ch4 beats ch1
    set_stb(2, 24'h000222); tick(); idle(3);
    pop(d); check(d, {1'b0, 7'd2, 24'h000222}, "R6 single ch2");
    set_stb(1, 24'h000111); set_stb(4, 24'h000444); tick(); idle(4);
    pop(d); check(d, {1'b0, 7'd4, 24'h000444}, "R6 rotation ch4 before ch1");
    pop(d); check(d, {1'b0, 7'd1, 24'h000111}, "R6 rotation ch1 second");

    // R8 empty read
    pop(d); check(d, 32'h0, "R8 empty read returns zero");
    check({31'b0, q_empty}, 32'h1, "R8 empty read leaves queue empty");

    // R9 latency: strobe sampled at edge k, visible after edge k+1
    set_stb(6, 24'h000666); tick();
    check({31'b0, q_empty}, 32'h1, "R9 still empty after first edge");
    @(negedge clk);
    check({31'b0, q_empty}, 32'h0, "R9 non-empty after second edge");
    check({31'b0, irq}, 32'h1, "R9 irq high");
    pop(d); check(d, {1'b0, 7'd6, 24'h000666}, "R9 entry ch6");

    // R5 disabled channel
    ref_en[7] = 1'b0;
    set_stb(7, 24'h000777); tick(); idle(3);
    check({31'b0, q_empty}, 32'h1, "R5 disabled strobe ignored");
    ref_en[7] = 1'b1;
    set_stb(7, 24'h000005); tick(); idle(3);
    pop(d); check(d, {1'b0, 7'd7, 24'h000005}, "R5 no loss marker from disabled strobe");

    // R3 / R4 fill with 40 back-to-back tags on ch0
    for (int i = 0; i < 40; i++) begin
      set_stb(0, 24'(i));
      @(negedge clk);
    end
    ref_stb = '0;
    idle(4);
    for (int i = 0; i < 32; i++) begin
      pop(d); check(d, {1'b0, 7'd0, 24'(i)}, "R3 stored entry in order");
    end
    check({31'b0, q_empty}, 32'h1, "R3 capacity exactly 32");
    set_stb(0, 24'h000ABC); tick(); idle(3);
    pop(d); check(d, {1'b1, 7'd0, 24'h000ABC}, "R4 disc set after overflow");
    set_stb(0, 24'h000DEF); tick(); idle(3);
    pop(d); check(d, {1'b0, 7'd0, 24'h000DEF}, "R4 disc cleared afterwards");

    // R7 slot overwrite: ch0..3 strobe twice, last grant was ch0
    for (int c = 0; c < 4; c++) set_stb(c, 24'(12'h100 + c));
    @(negedge clk);
    for (int c = 0; c < 4; c++) set_stb(c, 24'(12'h200 + c));
    tick(); idle(6);
    pop(d); check(d, {1'b0, 7'd1, 24'h000101}, "R7 first entry ch1");
    pop(d); check(d, {1'b1, 7'd2, 24'h000102}, "R7 loss marks next entry");
    pop(d); check(d, {1'b0, 7'd3, 24'h000103}, "R7 third entry ch3");
    pop(d); check(d, {1'b0, 7'd0, 24'h000100}, "R7 fourth entry ch0");
    pop(d); check(d, {1'b0, 7'd1, 24'h000201}, "R7 refilled ch1 tag");
    check({31'b0, q_empty}, 32'h1, "R7 lost tags not stored");

    // R2 last output channel
    set_stb(39, 24'h039039); tick(); idle(3);
    pop(d); check(d, {1'b0, 7'd39, 24'h039039}, "R2 output ch7 id 39");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule